// File: doc/BRIEF.md
# Fuse array command sequencer

The sequencer sits between a host and a one-time-programmable fuse macro. The macro is driven through a 32-bit control word and four 32-bit data registers. The host asks for one 16-bit halfword at a byte offset. It can ask for a logical read, which goes through the macro's remapping, a physical read, or a physical write. For every access the sequencer builds a control word and raises its start flag. It then polls the flag's readback at a fixed cycle spacing until the macro drops it, or until a poll budget runs out.

A read picks one halfword out of the returned 16-byte block. A logical read also reports the physical block number that the macro returns. A write is a read-modify-write of the whole block. The block is first read physically, then the halfword is merged into one of the four words, then all four words are written back in the same cycle, and then a program command is started.

The controller is a single state machine with seven states:

- `S_IDLE` waits for `req`.
- `S_ISSUE` writes the first control word.
- `S_WAIT` polls that command.
- `S_MERGE` pushes the merged block, and is used by writes only.
- `S_COMMIT` writes the program control word.
- `S_WAIT_WR` polls the program command.
- `S_FINISH` pulses `done`.

The transitions are:

- IDLE→ISSUE on `req`.
- ISSUE→WAIT always.
- WAIT→MERGE on poll end for a write.
- WAIT→FINISH on poll end for a read.
- MERGE→COMMIT always.
- COMMIT→WAIT_WR always.
- WAIT_WR→FINISH on poll end.
- FINISH→IDLE always.

Top module: `efz_seq`

## Requirements
- R1: After reset, `done`, `timeout`, `fz_ctrl_we` and `fz_dat_we` are all 0.
- R2: Every control word write sets bit 30 (start flag). It puts the offset with its low four bits cleared in bits 25:16, and the mode in bits 7:6. The modes are 0 for logical read, 1 for physical read and 3 for program. `op` selects the operation: 0 is a logical read, 1 is a physical read, and 2 or 3 is a write.
- R3: After a start, `fz_kick_rb` is sampled every `POLL_GAP` cycles. The sequence moves on only after a sample sees it low, unless R4 applies.
- R4: If `POLL_MAX` samples all see `fz_kick_rb` high, the sequence moves on anyway and `timeout` is 1 when `done` pulses.
- R5: Data register k sits at bits 32k+31:32k of `fz_dat_rd`/`fz_dat_wr`. Register 3 holds block bytes 3..0 and register 0 holds bytes 15..12, with the lowest byte at the word's LSB. The register used is 3 minus offset bits 3:2.
- R6: The read halfword is the chosen word shifted right by 8×offset[1:0], low 16 bits. For offset[1:0]=3 the upper byte is 0.
- R7: A logical read loads `aout` from `fz_aout`. When that value is all ones (0x3F), `rdata` is 0xFFFF whatever the data registers hold.
- R8: Physical reads and writes leave `aout` unchanged.
- R9: A write issues a physical read, then drives all four merged words with `fz_dat_we` high for one cycle, then issues the program word in the next cycle. The upper half of the target word is replaced when offset mod 4 is not 0, otherwise the lower half. All other bytes keep the values read.
- R10: Each accepted request gives exactly one one-cycle `done` pulse, and `timeout` is cleared when a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request, taken in idle |
| op | input | 2 | 0 logical read, 1 physical read, 2/3 write |
| offset | input | ADDR_W | Byte offset of the halfword |
| wdata | input | 16 | Halfword to write |
| rdata | output | 16 | Halfword read |
| aout | output | AOUT_W | Block number from the last logical read |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | A poll ran out during the last request |
| fz_ctrl | output | 32 | Control word to the macro |
| fz_ctrl_we | output | 1 | Control word write strobe |
| fz_kick_rb | input | 1 | Start flag readback, high while busy |
| fz_aout | input | AOUT_W | Physical block result of a logical read |
| fz_dat_rd | input | 128 | Four data registers, read side |
| fz_dat_wr | output | 128 | Four data registers, write side |
| fz_dat_we | output | 1 | Data register write strobe |

## Verification
The bench builds the block with `POLL_MAX`=5 and `POLL_GAP`=3. This keeps a full poll budget at about fifteen cycles. A macro model that holds its start flag high can therefore push the sequencer into the timeout path quickly. A macro latency of 10 cycles spans several poll samples. That exercises the non-expired multi-sample path as well. `ADDR_W`=10 keeps the full 64-block fuse space. This lets logical remapping, unmapped blocks and physical writes be observed through later reads.

// File: rtl/efz_pkg.sv
package efz_pkg;
    localparam int KICK_BIT = 30;
    localparam int ADDR_LSB = 16;
    localparam int ADDR_MSB = 25;
    localparam int MODE_LSB = 6;
    localparam int FIELD_W  = ADDR_MSB - ADDR_LSB + 1;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 32;
    localparam int NWORD    = 4;
    localparam int BLK_W    = WORD_W * NWORD;

    typedef enum logic [1:0] {
        MD_LOG = 2'd0,
        MD_PHY = 2'd1,
        MD_PGM = 2'd3
    } efz_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_MERGE,
        S_COMMIT,
        S_WAIT_WR,
        S_FINISH
    } efz_state_e;
endpackage

// File: rtl/efz_poll.sv
module efz_poll #(
    parameter int POLL_MAX = 100,
    parameter int POLL_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic busy_i,
    output logic fin,
    output logic expired
);
    localparam int GAP_W = $clog2(POLL_GAP + 1);
    localparam int TRY_W = $clog2(POLL_MAX + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(POLL_GAP - 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_MAX - 1);

    logic             active;
    logic [GAP_W-1:0] gap_cnt;
    logic [TRY_W-1:0] try_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active  <= 1'b0;
            gap_cnt <= '0;
            try_cnt <= '0;
            fin     <= 1'b0;
            expired <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                active  <= 1'b1;
                gap_cnt <= '0;
                try_cnt <= '0;
                expired <= 1'b0;
            end else if (active) begin
                if (gap_cnt == GAP_LAST) begin
                    gap_cnt <= '0;
                    if (!busy_i) begin
                        fin    <= 1'b1;
                        active <= 1'b0;
                    end else if (try_cnt == TRY_LAST) begin
                        fin     <= 1'b1;
                        expired <= 1'b1;
                        active  <= 1'b0;
                    end else begin
                        try_cnt <= try_cnt + 1'b1;
                    end
                end else begin
                    gap_cnt <= gap_cnt + 1'b1;
                end
            end
        end
    end

    // R3: a normal poll end only follows a sample that saw the flag low
    a_r3_end_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !expired) |-> $past(!busy_i));
endmodule

// File: rtl/efz_lane.sv
module efz_lane
    import efz_pkg::*;
(
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [3:0]        sel_i,
    input  logic [HALF_W-1:0] wdata_i,
    output logic [HALF_W-1:0] half_o,
    output logic [BLK_W-1:0]  blk_o
);
    logic [1:0]        word_idx;
    logic [WORD_W-1:0] word;
    logic              upper;

    assign word_idx = 2'(NWORD - 1) - sel_i[3:2];
    assign word     = blk_i[word_idx*WORD_W +: WORD_W];
    assign half_o   = HALF_W'(word >> {sel_i[1:0], 3'b000});
    assign upper    = (sel_i[1:0] != 2'b00);

    for (genvar k = 0; k < NWORD; k++) begin : g_word
        logic hit;
        assign hit = (word_idx == 2'(k));
        always_comb begin
            blk_o[k*WORD_W +: WORD_W] = blk_i[k*WORD_W +: WORD_W];
            if (hit) begin
                if (upper)
                    blk_o[k*WORD_W + HALF_W +: HALF_W] = wdata_i;
                else
                    blk_o[k*WORD_W +: HALF_W] = wdata_i;
            end
        end
    end
endmodule

// File: rtl/efz_seq.sv
module efz_seq
    import efz_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int AOUT_W   = 6,
    parameter int POLL_MAX = 100,
    parameter int POLL_GAP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        op,
    input  logic [ADDR_W-1:0] offset,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [AOUT_W-1:0] aout,
    output logic              done,
    output logic              timeout,
    output logic [31:0]       fz_ctrl,
    output logic              fz_ctrl_we,
    input  logic              fz_kick_rb,
    input  logic [AOUT_W-1:0] fz_aout,
    input  logic [127:0]      fz_dat_rd,
    output logic [127:0]      fz_dat_wr,
    output logic              fz_dat_we
);
    localparam logic [AOUT_W-1:0] UNMAPPED = {AOUT_W{1'b1}};

    efz_state_e        state_q, state_d;
    logic              is_wr_q, is_phys_q;
    logic [ADDR_W-1:0] off_q;
    logic [15:0]       wdata_q;
    logic [15:0]       rdata_q;
    logic [AOUT_W-1:0] aout_q;
    logic              timeout_q;

    logic              accept;
    logic              poll_fin, poll_exp;
    logic [15:0]       lane_half;
    logic [FIELD_W-1:0] addr_field;
    efz_mode_e         cur_mode;

    assign accept     = (state_q == S_IDLE) && req;
    assign addr_field = FIELD_W'({off_q[ADDR_W-1:4], 4'b0000});

    efz_poll #(.POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_poll (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (fz_ctrl_we),
        .busy_i  (fz_kick_rb),
        .fin     (poll_fin),
        .expired (poll_exp)
    );

    efz_lane u_lane (
        .blk_i   (fz_dat_rd),
        .sel_i   (off_q[3:0]),
        .wdata_i (wdata_q),
        .half_o  (lane_half),
        .blk_o   (fz_dat_wr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // request and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            is_wr_q   <= 1'b0;
            is_phys_q <= 1'b0;
            off_q     <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            aout_q    <= '0;
            timeout_q <= 1'b0;
        end else begin
            if (accept) begin
                is_wr_q   <= op[1];
                is_phys_q <= op[1] | op[0];
                off_q     <= offset;
                wdata_q   <= wdata;
                timeout_q <= 1'b0;
            end else if (poll_fin && poll_exp) begin
                timeout_q <= 1'b1;
            end
            if (state_q == S_WAIT && poll_fin && !is_wr_q) begin
                if (!is_phys_q) begin
                    aout_q  <= fz_aout;
                    rdata_q <= (fz_aout == UNMAPPED) ? 16'hFFFF : lane_half;
                end else begin
                    rdata_q <= lane_half;
                end
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        fz_ctrl_we = 1'b0;
        fz_dat_we  = 1'b0;
        done       = 1'b0;
        cur_mode   = is_phys_q ? MD_PHY : MD_LOG;
        unique case (state_q)
            S_IDLE:    if (req) state_d = S_ISSUE;
            S_ISSUE: begin
                fz_ctrl_we = 1'b1;
                state_d    = S_WAIT;
            end
            S_WAIT:    if (poll_fin) state_d = is_wr_q ? S_MERGE : S_FINISH;
            S_MERGE: begin
                fz_dat_we = 1'b1;
                state_d   = S_COMMIT;
            end
            S_COMMIT: begin
                fz_ctrl_we = 1'b1;
                cur_mode   = MD_PGM;
                state_d    = S_WAIT_WR;
            end
            S_WAIT_WR: if (poll_fin) state_d = S_FINISH;
            S_FINISH: begin
                done    = 1'b1;
                state_d = S_IDLE;
            end
            default:   state_d = S_IDLE;
        endcase
        fz_ctrl                    = '0;
        fz_ctrl[KICK_BIT]          = fz_ctrl_we;
        fz_ctrl[ADDR_MSB:ADDR_LSB] = addr_field;
        fz_ctrl[MODE_LSB +: 2]     = cur_mode;
    end

    assign rdata   = rdata_q;
    assign aout    = aout_q;
    assign timeout = timeout_q;

    // R2: control writes carry the start flag, an aligned address and a legal mode
    a_r2_ctrl_fields: assert property (@(posedge clk) disable iff (!rst_n)
        fz_ctrl_we |-> (fz_ctrl[KICK_BIT] && fz_ctrl[ADDR_LSB +: 4] == 4'h0
                        && fz_ctrl[MODE_LSB +: 2] != 2'b10));

    // R9: the merged block is followed at once by the program command
    a_r9_push_then_program: assert property (@(posedge clk) disable iff (!rst_n)
        fz_dat_we |=> (fz_ctrl_we && fz_ctrl[MODE_LSB +: 2] == 2'b11));

    // R10: completion is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: an unmapped logical result returns all ones
    a_r7_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_phys_q && aout == UNMAPPED) |-> rdata == 16'hFFFF);

    // R4: timeout only rises after a sample that saw the flag still high
    a_r4_timeout_stuck: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(fz_kick_rb, 2));
endmodule

// File: tb/efz_seq_bench.sv
module efz_seq_bench;
    localparam int AW = 10;
    localparam int PM = 5;
    localparam int PG = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  op = '0;
    logic [AW-1:0] offset = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [5:0]  aout;
    logic        done, timeout;
    logic [31:0] fz_ctrl;
    logic        fz_ctrl_we, fz_dat_we;
    logic        fz_kick_rb;
    logic [5:0]  fz_aout;
    logic [127:0] fz_dat_rd, fz_dat_wr;

    always #2.5 clk = ~clk;

    efz_seq #(.ADDR_W(AW), .AOUT_W(6), .POLL_MAX(PM), .POLL_GAP(PG)) u_efz_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .op(op), .offset(offset), .wdata(wdata),
        .rdata(rdata), .aout(aout), .done(done), .timeout(timeout),
        .fz_ctrl(fz_ctrl), .fz_ctrl_we(fz_ctrl_we), .fz_kick_rb(fz_kick_rb),
        .fz_aout(fz_aout), .fz_dat_rd(fz_dat_rd), .fz_dat_wr(fz_dat_wr), .fz_dat_we(fz_dat_we)
    );

    // ---------------- fuse macro model ----------------
    logic [127:0] mem [64];
    logic [31:0]  dreg [4];
    logic         busy;
    int           cnt;
    int           lat = 4;
    logic         hang = 1'b0;
    logic [1:0]   m_mode;
    logic [5:0]   m_blk;
    logic [5:0]   m_aout;

    function automatic logic [7:0] byteval(int p, int i);
        return 8'((p * 16 + i) * 7 + 3);
    endfunction

    always_comb for (int k = 0; k < 4; k++) fz_dat_rd[32*k +: 32] = dreg[k];
    assign fz_kick_rb = busy;
    assign fz_aout    = m_aout;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= 0;
            m_mode <= '0;
            m_blk  <= '0;
            m_aout <= '0;
            for (int k = 0; k < 4; k++) dreg[k] <= '0;
            for (int p = 0; p < 64; p++)
                for (int i = 0; i < 16; i++) mem[p][8*i +: 8] <= byteval(p, i);
        end else begin
            if (fz_dat_we) for (int k = 0; k < 4; k++) dreg[k] <= fz_dat_wr[32*k +: 32];
            if (fz_ctrl_we && fz_ctrl[30]) begin
                busy   <= 1'b1;
                cnt    <= lat;
                m_mode <= fz_ctrl[7:6];
                m_blk  <= fz_ctrl[25:20];
            end else if (busy && !hang) begin
                if (cnt > 1) cnt <= cnt - 1;
                else begin
                    busy <= 1'b0;
                    case (m_mode)
                        2'd0: begin
                            if (m_blk < 6'd48) begin
                                m_aout <= m_blk + 6'd8;
                                for (int k = 0; k < 4; k++)
                                    dreg[k] <= mem[m_blk + 6'd8][32*(3-k) +: 32];
                            end else begin
                                m_aout <= 6'h3F;
                                for (int k = 0; k < 4; k++) dreg[k] <= 32'hDEADBEEF;
                            end
                        end
                        2'd1: for (int k = 0; k < 4; k++) dreg[k] <= mem[m_blk][32*(3-k) +: 32];
                        2'd3: for (int k = 0; k < 4; k++) mem[m_blk][32*(3-k) +: 32] <= dreg[k];
                        default: ;
                    endcase
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic        chk_r;
        logic [15:0] r;
        logic        chk_a;
        logic [5:0]  a;
        logic        to;
    } exp_t;

    exp_t        sq[$];
    string       tq[$];
    logic [11:0] mq[$];
    logic [7:0]  sh [64][16];
    logic [5:0]  last_a = '0;
    int nchk = 0, nfail = 0;
    bit ended = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("  %0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    endtask

    function automatic logic [15:0] exp_half(int p, logic [3:0] o);
        logic [7:0] lo, hi;
        lo = sh[p][o];
        hi = (o[1:0] == 2'd3) ? 8'h00 : sh[p][o + 4'd1];
        return {hi, lo};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (fz_ctrl_we) begin
                if (mq.size() == 0) check(0, "R2 unexpected control write", fz_ctrl, 0);
                else begin
                    logic [11:0] em;
                    em = mq.pop_front();
                    check({fz_ctrl[7:6], fz_ctrl[25:16]} == em && fz_ctrl[30],
                          "R2/R9 control word mode+address", {fz_ctrl[7:6], fz_ctrl[25:16]}, em);
                end
            end
            if (done) begin
                if (sq.size() == 0) check(0, "R10 unexpected done", 1, 0);
                else begin
                    exp_t  e;
                    string t;
                    e = sq.pop_front();
                    t = tq.pop_front();
                    if (e.chk_r) check(rdata == e.r, {t, " rdata"}, rdata, e.r);
                    if (e.chk_a) check(aout == e.a, {t, " aout"}, aout, e.a);
                    check(timeout == e.to, {t, " timeout (R4/R10)"}, timeout, e.to);
                    if (!e.to) check(!fz_kick_rb, {t, " R3 done before flag clear"}, fz_kick_rb, 0);
                end
            end
        end
    end

    task automatic do_op(input logic [1:0] o, input logic [9:0] off, input logic [15:0] wd,
                         input logic to_exp, input string tag);
        exp_t e;
        int   b;
        logic [9:0] addr;
        logic [3:0] base;
        b    = int'(off[9:4]);
        addr = {off[9:4], 4'b0000};
        e    = '0;
        e.to = to_exp;
        if (o == 2'd0) begin
            e.chk_r = 1; e.chk_a = 1;
            if (b < 48) begin e.r = exp_half(b + 8, off[3:0]); e.a = 6'(b + 8); end
            else        begin e.r = 16'hFFFF;                 e.a = 6'h3F;     end
            last_a = e.a;
            mq.push_back({2'd0, addr});
        end else if (o == 2'd1) begin
            e.chk_r = !to_exp; e.r = exp_half(b, off[3:0]);
            e.chk_a = 1; e.a = last_a;
            mq.push_back({2'd1, addr});
        end else begin
            e.chk_a = 1; e.a = last_a;
            mq.push_back({2'd1, addr});
            mq.push_back({2'd3, addr});
            base = off[3:0] & 4'hC;
            if (off[1:0] != 2'd0) begin
                sh[b][base + 4'd2] = wd[7:0]; sh[b][base + 4'd3] = wd[15:8];
            end else begin
                sh[b][base] = wd[7:0]; sh[b][base + 4'd1] = wd[15:8];
            end
        end
        sq.push_back(e);
        tq.push_back(tag);
        @(negedge clk);
        req = 1'b1; op = o; offset = off; wdata = wd;
        @(negedge clk);
        req = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        for (int p = 0; p < 64; p++)
            for (int i = 0; i < 16; i++) sh[p][i] = byteval(p, i);
        repeat (3) @(negedge clk);
        // R1: idle outputs after reset
        check(!done && !timeout && !fz_ctrl_we && !fz_dat_we, "R1 reset outputs",
              {done, timeout, fz_ctrl_we, fz_dat_we}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        do_op(2'd0, 10'h034, 16'h0, 0, "R5 logical read word select");
        do_op(2'd0, 10'h12B, 16'h0, 0, "R6 logical read offset mod4=3");
        do_op(2'd0, 10'h325, 16'h0, 0, "R7 unmapped logical read");
        do_op(2'd1, 10'h0A6, 16'h0, 0, "R8 physical read keeps aout");
        lat = 10;
        do_op(2'd1, 10'h0AF, 16'h0, 0, "R3 multi-sample poll");
        lat = 4;
        do_op(2'd1, 10'h0A1, 16'h0, 0, "R6 physical read offset mod4=1");
        do_op(2'd2, 10'h056, 16'hA1B2, 0, "R9 write upper half");
        do_op(2'd1, 10'h056, 16'h0, 0, "R9 readback written half");
        do_op(2'd1, 10'h054, 16'h0, 0, "R9 neighbour half untouched");
        do_op(2'd1, 10'h05C, 16'h0, 0, "R9 other word untouched");
        do_op(2'd2, 10'h058, 16'h1357, 0, "R9 write lower half");
        do_op(2'd1, 10'h058, 16'h0, 0, "R9 readback lower half");
        do_op(2'd2, 10'h05B, 16'h9ACE, 0, "R9 write offset mod4=3");
        do_op(2'd1, 10'h05A, 16'h0, 0, "R9 readback upper via mod4=3");
        do_op(2'd1, 10'h059, 16'h0, 0, "R6 straddling read");
        do_op(2'd2, 10'h0D2, 16'h4C4D, 0, "R9 write physical block 13");
        do_op(2'd0, 10'h052, 16'h0, 0, "R5 logical read sees program");
        hang = 1'b1;
        do_op(2'd1, 10'h070, 16'h0, 1, "R4 poll budget expires");
        hang = 1'b0;
        do_op(2'd1, 10'h070, 16'h0, 0, "R10 timeout cleared on next request");
        do_op(2'd0, 10'h3F0, 16'h0, 0, "R7 unmapped top block");

        repeat (4) @(negedge clk);
        check(sq.size() == 0 && mq.size() == 0, "R10 every request completed once",
              sq.size() + mq.size(), 0);
        summary();
    end
endmodule